// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block sequences the low-power state of a small processor core. The instruction decoder raises a one-cycle strobe when it executes a sleep instruction. The controller then checks whether any interrupt source has both its enable and its flag set. If one does, the instruction is treated as a no-operation. If none does, the core enters sleep: the oscillator enable drops, the watchdog gets a clear pulse, and the power-down and time-out status bits are updated.

While asleep, three events end the sleep. The external reset input causes a full reset. A watchdog time-out resumes execution at the next instruction. An enabled interrupt also resumes execution. For an interrupt wake, the global interrupt enable decides whether the core then branches to the interrupt vector at 0x0004. Every wake is reported on a one-cycle valid strobe with a 2-bit action code and comes with a watchdog clear pulse. A watchdog time-out while the core is running produces a reset request. That reset request does not come from the external reset pin.

The controller has two states. RUN is the awake state. SLEEP is the state with the clock stopped. It has these named transitions:
- RUN to SLEEP on a committed sleep ("enter").
- RUN to RUN on a no-operation sleep or a running time-out ("nop", "run_timeout").
- SLEEP to RUN on a watchdog or interrupt wake ("wdt_wake", "irq_wake").
- Any state to RUN under external reset ("ext_reset").

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A clock edge with `ext_rst_n` low sets `pd` and `to` to 1, forces the RUN state (`osc_en`=1) and makes `rst_req` 1 in the following cycle. If the controller was in SLEEP at that edge, the following cycle also shows `wake_vld`=1 with `wake_code`=2'b10 (reset) and `wdt_clr`=1.
- R2: The interrupt wake condition is the OR over all lanes of `irq_en[i] & irq_flag[i]`. A lane only counts when both of its bits are 1 in the same lane.
- R3: In RUN, a `sleep_req` with no pending interrupt and no `wdt_to` commits sleep. In the next cycle `osc_en`=0, `pd`=0, `to`=1 and `wdt_clr`=1.
- R4: In RUN, a `sleep_req` that arrives while an interrupt is pending acts as a no-operation. `osc_en` stays 1, `pd` and `to` keep their values, and no `wdt_clr` or `wake_vld` pulse appears.
- R5: In SLEEP, a pending interrupt wakes the core in the next cycle with `osc_en`=1, `wake_vld`=1 and `wdt_clr`=1. `wake_code` is 2'b01 (resume then vector) if `gie` was 1, and 2'b00 (resume) if `gie` was 0. `pd` and `to` are left unchanged.
- R6: A flag that becomes pending in the cycle after `sleep_req` does not stop the commit. Sleep is entered, and the core wakes one cycle later. This gives `wdt_clr` high in two consecutive cycles.
- R7: In SLEEP, `wdt_to` wakes the core with `wake_code`=2'b00 whatever `gie` is. It clears `to`, pulses `wdt_clr` and does not raise `rst_req`.
- R8: Wake sources are arbitrated in a fixed order: external reset first, then watchdog time-out, then interrupt. When a time-out and a pending interrupt arrive together in SLEEP, the result is `wake_code`=2'b00 with `to`=0.
- R9: In RUN, `wdt_to` raises `rst_req` for exactly one cycle and clears `to`. It leaves `pd` and `osc_en` unchanged, and a `sleep_req` in the same cycle is ignored.
- R10: In SLEEP, enables and flags that are set only in different lanes keep the core asleep. `osc_en` stays 0 and `wake_vld` stays 0.
- R11: With no stimulus, `wdt_clr`, `wake_vld` and `rst_req` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset, synchronous, active low |
| sleep_req | input | 1 | One-cycle strobe from the decoder when a sleep instruction executes |
| wdt_to | input | 1 | Watchdog time-out pulse |
| gie | input | 1 | Global interrupt enable |
| irq_en | input | NSRC | Per-source interrupt enables |
| irq_flag | input | NSRC | Per-source interrupt flags |
| osc_en | output | 1 | Core oscillator enable; 0 while asleep |
| wdt_clr | output | 1 | Watchdog clear pulse |
| pd | output | 1 | Power-down status bit |
| to | output | 1 | Time-out status bit |
| rst_req | output | 1 | Device reset request |
| wake_vld | output | 1 | One-cycle wake-report strobe |
| wake_code | output | 2 | Wake action: 00 resume, 01 resume then vector, 10 reset |

## Verification
The bench builds the controller with `NSRC`=4. This keeps every lane of the enable/flag vectors small enough to address one at a time. It also makes it possible to drive complementary masks such as 0101 against 1010, so that no lane ever has both bits set. The directed scenarios place each wake source, and each pair of colliding sources, on the exact cycle relative to the sleep strobe. This covers the no-operation case, the late-flag case and the time-out-versus-interrupt collision, each on its boundary cycle.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } sw_state_e;

    typedef enum logic [1:0] {
        WK_RESUME = 2'b00,
        WK_VECTOR = 2'b01,
        WK_RESET  = 2'b10
    } wake_code_e;

endpackage

// File: rtl/sw_wake_detect.sv
module sw_wake_detect #(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0] irq_en,
    input  logic [NSRC-1:0] irq_flag,
    output logic            pending
);

    logic [NSRC-1:0] lane_hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        assign lane_hit[i] = irq_en[i] & irq_flag[i];
    end

    assign pending = |lane_hit;

    always_comb begin
        AST_PENDING_NEEDS_PAIR: assert (!pending || ((irq_en & irq_flag) != '0)); // R2
    end

endmodule

// File: rtl/sw_status_bits.sv
module sw_status_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic wdt_hit_i,
    output logic pd_o,
    output logic to_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_o <= 1'b1;
            to_o <= 1'b1;
        end else begin
            if (enter_i) begin
                pd_o <= 1'b0;
                to_o <= 1'b1;
            end else if (wdt_hit_i) begin
                to_o <= 1'b0;
            end
        end
    end

    AST_PD_FALLS_ONLY_ON_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_o) |-> $past(enter_i)); // R3

    AST_TO_FALLS_ONLY_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(to_o) |-> $past(wdt_hit_i)); // R7

endmodule

// File: rtl/sw_fsm.sv
module sw_fsm
    import sw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       pending,
    input  logic       wdt_to,
    input  logic       gie,
    output logic       enter,
    output logic       wdt_hit,
    output logic       osc_en,
    output logic       wdt_clr,
    output logic       wake_vld,
    output wake_code_e wake_code,
    output logic       rst_req
);

    sw_state_e state, nxt;
    logic      irq_wake;
    logic      wdt_wake;
    logic      run_timeout;

    always_comb begin
        nxt         = state;
        enter       = 1'b0;
        wdt_hit     = 1'b0;
        irq_wake    = 1'b0;
        wdt_wake    = 1'b0;
        run_timeout = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (wdt_to) begin
                    run_timeout = 1'b1;
                    wdt_hit     = 1'b1;
                end else if (sleep_req && !pending) begin
                    enter = 1'b1;
                    nxt   = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (wdt_to) begin
                    wdt_wake = 1'b1;
                    wdt_hit  = 1'b1;
                    nxt      = ST_RUN;
                end else if (pending) begin
                    irq_wake = 1'b1;
                    nxt      = ST_RUN;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req   <= 1'b1;
            wake_vld  <= (state == ST_SLEEP);
            wdt_clr   <= (state == ST_SLEEP);
            wake_code <= WK_RESET;
        end else begin
            rst_req   <= run_timeout;
            wake_vld  <= irq_wake | wdt_wake;
            wdt_clr   <= enter | irq_wake | wdt_wake;
            wake_code <= (irq_wake && gie) ? WK_VECTOR : WK_RESUME;
        end
    end

    assign osc_en = (state != ST_SLEEP);

    AST_WAKE_CLEARS_WDT: assert property (@(posedge clk) disable iff (!rst_n)
        wake_vld |-> wdt_clr); // R5

    AST_VECTOR_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_vld && wake_code == WK_VECTOR) |-> $past(gie)); // R5

    AST_CLOCK_BACK_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> wake_vld); // R5

    AST_RST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !$past(wdt_to)) |=> !rst_req); // R9

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import sw_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            ext_rst_n,
    input  logic            sleep_req,
    input  logic            wdt_to,
    input  logic            gie,
    input  logic [NSRC-1:0] irq_en,
    input  logic [NSRC-1:0] irq_flag,
    output logic            osc_en,
    output logic            wdt_clr,
    output logic            pd,
    output logic            to,
    output logic            rst_req,
    output logic            wake_vld,
    output logic [1:0]      wake_code
);

    logic       pending;
    logic       enter;
    logic       wdt_hit;
    wake_code_e code_q;

    sw_wake_detect #(.NSRC(NSRC)) u_detect (
        .irq_en   (irq_en),
        .irq_flag (irq_flag),
        .pending  (pending)
    );

    sw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (ext_rst_n),
        .sleep_req (sleep_req),
        .pending   (pending),
        .wdt_to    (wdt_to),
        .gie       (gie),
        .enter     (enter),
        .wdt_hit   (wdt_hit),
        .osc_en    (osc_en),
        .wdt_clr   (wdt_clr),
        .wake_vld  (wake_vld),
        .wake_code (code_q),
        .rst_req   (rst_req)
    );

    sw_status_bits u_status (
        .clk       (clk),
        .rst_n     (ext_rst_n),
        .enter_i   (enter),
        .wdt_hit_i (wdt_hit),
        .pd_o      (pd),
        .to_o      (to)
    );

    assign wake_code = code_q;

    AST_SLEEP_COMMIT: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (osc_en && sleep_req && !pending && !wdt_to) |=> (!osc_en && !pd && to && wdt_clr)); // R3

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (osc_en && sleep_req && pending && !wdt_to) |=> (osc_en && !wdt_clr && $stable(pd) && $stable(to))); // R4

    AST_RUN_TIMEOUT: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (osc_en && wdt_to) |=> (rst_req && !to && osc_en)); // R9

    AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!osc_en && !pending && !wdt_to) |=> (!osc_en && !wake_vld)); // R10

endmodule

// File: tb/tb_sleep_wake_ctrl.sv
module tb_sleep_wake_ctrl;

    localparam int NSRC = 4;

    logic            clk = 1'b0;
    logic            ext_rst_n = 1'b0;
    logic            sleep_req = 1'b0;
    logic            wdt_to = 1'b0;
    logic            gie = 1'b0;
    logic [NSRC-1:0] irq_en = '0;
    logic [NSRC-1:0] irq_flag = '0;
    logic            osc_en, wdt_clr, pd, to, rst_req, wake_vld;
    logic [1:0]      wake_code;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sleep_wake_ctrl #(.NSRC(NSRC)) dut (
        .clk (clk), .ext_rst_n (ext_rst_n), .sleep_req (sleep_req),
        .wdt_to (wdt_to), .gie (gie), .irq_en (irq_en), .irq_flag (irq_flag),
        .osc_en (osc_en), .wdt_clr (wdt_clr), .pd (pd), .to (to),
        .rst_req (rst_req), .wake_vld (wake_vld), .wake_code (wake_code)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // commit a sleep from RUN with nothing pending; checks R3
    task automatic enter_sleep();
        irq_en = '0; irq_flag = '0;
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        chk("R3", "osc_en", osc_en, 0);
        chk("R3", "pd", pd, 0);
        chk("R3", "to", to, 1);
        chk("R3", "wdt_clr", wdt_clr, 1);
    endtask

    task automatic t_reset();
        ext_rst_n = 1'b0;
        tick(); tick();
        chk("R1", "pd", pd, 1);
        chk("R1", "to", to, 1);
        chk("R1", "osc_en", osc_en, 1);
        chk("R1", "rst_req", rst_req, 1);
        chk("R1", "wake_vld", wake_vld, 0);
        ext_rst_n = 1'b1;
        tick();
        chk("R1", "rst_req released", rst_req, 0);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R11", "wdt_clr idle", wdt_clr, 0);
            chk("R11", "wake_vld idle", wake_vld, 0);
            chk("R11", "rst_req idle", rst_req, 0);
        end
    endtask

    task automatic t_nop();
        irq_en = 4'b0100; irq_flag = 4'b0100;
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        chk("R4", "osc_en", osc_en, 1);
        chk("R4", "pd", pd, 1);
        chk("R4", "to", to, 1);
        chk("R4", "wdt_clr", wdt_clr, 0);
        chk("R4", "wake_vld", wake_vld, 0);
        irq_en = '0; irq_flag = '0;
        tick();
    endtask

    task automatic t_irq_wake(input logic g, input int lane);
        gie = g;
        enter_sleep();
        tick();
        chk("R3", "wdt_clr single", wdt_clr, 0);
        chk("R3", "still asleep", osc_en, 0);
        irq_en[lane] = 1'b1; irq_flag[lane] = 1'b1;
        tick();
        chk("R5", "osc_en", osc_en, 1);
        chk("R5", "wake_vld", wake_vld, 1);
        chk("R5", "wake_code", wake_code, g ? 2'b01 : 2'b00);
        chk("R5", "wdt_clr", wdt_clr, 1);
        chk("R5", "pd", pd, 0);
        chk("R5", "to", to, 1);
        irq_en = '0; irq_flag = '0;
        tick();
        chk("R5", "wake_vld one cycle", wake_vld, 0);
        gie = 1'b0;
    endtask

    task automatic t_mismatch_then_wdt();
        gie = 1'b1;
        enter_sleep();
        irq_en = 4'b0101; irq_flag = 4'b1010;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R10", "osc_en", osc_en, 0);
            chk("R10", "wake_vld", wake_vld, 0);
        end
        irq_en = '0; irq_flag = '0;
        wdt_to = 1'b1;
        tick();
        wdt_to = 1'b0;
        chk("R7", "osc_en", osc_en, 1);
        chk("R7", "wake_vld", wake_vld, 1);
        chk("R7", "wake_code", wake_code, 2'b00);
        chk("R7", "to", to, 0);
        chk("R7", "wdt_clr", wdt_clr, 1);
        chk("R7", "rst_req", rst_req, 0);
        gie = 1'b0;
        tick();
    endtask

    task automatic t_late_flag();
        gie = 1'b1;
        irq_en = '0; irq_flag = '0;
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        chk("R6", "committed osc_en", osc_en, 0);
        chk("R6", "committed pd", pd, 0);
        chk("R6", "committed to", to, 1);
        chk("R6", "first wdt_clr", wdt_clr, 1);
        irq_en = 4'b1000; irq_flag = 4'b1000;
        tick();
        chk("R6", "woke osc_en", osc_en, 1);
        chk("R6", "second wdt_clr", wdt_clr, 1);
        chk("R6", "wake_code", wake_code, 2'b01);
        irq_en = '0; irq_flag = '0;
        gie = 1'b0;
        tick();
    endtask

    task automatic t_priority();
        gie = 1'b1;
        enter_sleep();
        irq_en = 4'b0010; irq_flag = 4'b0010;
        wdt_to = 1'b1;
        tick();
        wdt_to = 1'b0;
        chk("R8", "wake_vld", wake_vld, 1);
        chk("R8", "wake_code", wake_code, 2'b00);
        chk("R8", "to", to, 0);
        irq_en = '0; irq_flag = '0;
        gie = 1'b0;
        tick();
    endtask

    task automatic t_run_timeout();
        logic pd_before;
        pd_before = pd;
        wdt_to = 1'b1; sleep_req = 1'b1;
        tick();
        wdt_to = 1'b0; sleep_req = 1'b0;
        chk("R9", "rst_req", rst_req, 1);
        chk("R9", "to", to, 0);
        chk("R9", "osc_en", osc_en, 1);
        chk("R9", "pd", pd, pd_before);
        chk("R9", "wdt_clr", wdt_clr, 0);
        tick();
        chk("R9", "rst_req one cycle", rst_req, 0);
    endtask

    task automatic t_reset_from_sleep();
        enter_sleep();
        tick();
        ext_rst_n = 1'b0;
        tick();
        chk("R1", "sleep reset wake_vld", wake_vld, 1);
        chk("R1", "sleep reset code", wake_code, 2'b10);
        chk("R1", "sleep reset wdt_clr", wdt_clr, 1);
        chk("R1", "sleep reset osc_en", osc_en, 1);
        chk("R1", "sleep reset pd", pd, 1);
        chk("R1", "sleep reset to", to, 1);
        chk("R1", "sleep reset rst_req", rst_req, 1);
        ext_rst_n = 1'b1;
        tick();
        chk("R1", "wake_vld after reset", wake_vld, 0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_nop();
        t_irq_wake(1'b0, 0);
        t_irq_wake(1'b1, 3);
        t_mismatch_then_wdt();
        t_late_flag();
        t_priority();
        t_run_timeout();
        t_reset_from_sleep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule